// File: doc/BRIEF.md
# Tapped-Prescaler Watchdog Timer

This block is a supervision timer for a small processor subsystem. The system clock first passes through a fixed divide-by-12 stage. A 13-bit binary prescaler follows it, and a 3-bit select chooses which prescaler stage, from 6 to 13, drives an 8-bit down counter. Software programs a control register and a reload register. It keeps the timer from expiring by writing a two-byte key sequence to a pair of feed addresses. A correct feed reloads the counter and clears the prescaler.

When the counter is at zero and another tick arrives, the block reloads the counter, clears the prescaler and sets an overflow flag. What happens next depends on the mode bit. In watchdog mode the block also drives a one-clock system reset request. In timer mode it raises a level interrupt request that lasts as long as the flag is set. The run bit is also driven out as a status signal, so the power manager can refuse power-down while the timer is active.

Top module: `wdt_tapped`

## Requirements
- R1: After reset, the control register reads 00h (bits 4:3 always read 0), the reload register reads FFh, and `wd_reset`, `irq` and `running` are low.
- R2: Register map on `addr`: 0 is control (bits 7:5 prescaler select, bit 2 run, bit 1 overflow flag, bit 0 mode with 1 meaning watchdog), 1 is reload, 2 is feed key 1 (a read returns the live counter), 3 is feed key 2 (a read returns 0).
- R3: While running, the counter takes one step every 12 × 2^(6+select) clock cycles.
- R4: A tick that arrives while the counter is 0 is an underflow. It reloads the counter and clears the prescaler, so reload value W gives a period of (W+1) ticks, and W = 0 gives exactly one full tick.
- R5: Writing A5h to address 2, with the next write being 5Ah to address 3, is a feed. It reloads the counter from the reload register and restarts the prescaler at zero.
- R6: Any other write pattern does not feed. Examples are a wrong key, the wrong order, or any other write placed between the two keys.
- R7: In watchdog mode, an underflow sets the flag and pulses `wd_reset` high for exactly one clock. `irq` stays low.
- R8: In timer mode, an underflow sets the flag and `irq` is high while the flag is set. No reset pulse is produced.
- R9: The flag stays set until software writes control bit 1 as 0.
- R10: Clearing the run bit freezes the divider, the prescaler and the counter. Setting it again resumes from the frozen values.
- R11: `running` follows the run bit, so the power manager can use it to refuse power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address, shared by reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| wd_reset | output | 1 | One-clock system reset request |
| tof_flag | output | 1 | Overflow flag |
| irq | output | 1 | Overflow interrupt request (timer mode only) |
| running | output | 1 | Timer is active, so power-down must be blocked |

## Verification
The bench times every expiry to the exact clock for several select values, including the slowest tap and a reload of zero. A design with an off-by-one divider or tap, or one that failed to clear the prescaler on reload, would produce its event a few cycles, or a whole tick, away from the predicted edge. Broken feed sequences are mixed in before a known deadline. A decoder that reloaded on a stray second key would push the expiry later, and the bench would report it as missing. The bench stops and restarts the timer in the middle of a tick and predicts the remaining time. A design that lost or reset the prescaler while stopped would expire at the wrong cycle. In both modes it also checks which of reset and interrupt appear, so swapped mode handling is caught.

// File: rtl/wdt_tapped.sv
module wdt_tapped #(
  parameter int DIV    = 12,
  parameter int PRE_W  = 13,
  parameter int TAP_LO = 6,
  parameter int SEL_W  = 3,
  parameter logic [7:0] KEY1 = 8'hA5,
  parameter logic [7:0] KEY2 = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wd_reset,
  output logic       tof_flag,
  output logic       irq,
  output logic       running
);
  localparam int DIV_W = $clog2(DIV);
  localparam logic [1:0] A_CTL = 2'd0, A_RLD = 2'd1, A_K1 = 2'd2, A_K2 = 2'd3;

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q, tap_mask;
  logic [7:0]       cnt_q, reload_q;
  logic [SEL_W-1:0] sel_q;
  logic             run_q, tof_q, mode_q, armed_q, pulse_q;

  assign tap_mask = (PRE_W'(1) << (TAP_LO + int'(sel_q))) - PRE_W'(1);

  wire div_tc = run_q && (div_q == DIV_W'(DIV - 1));
  wire tick   = div_tc && ((pre_q & tap_mask) == tap_mask);
  wire under  = tick && (cnt_q == 8'd0);
  wire wr_ctl = wr_en && (addr == A_CTL);
  wire feed   = wr_en && (addr == A_K2) && (wr_data == KEY2) && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      pre_q    <= '0;
      cnt_q    <= 8'hFF;
      reload_q <= 8'hFF;
      sel_q    <= '0;
      run_q    <= 1'b0;
      tof_q    <= 1'b0;
      mode_q   <= 1'b0;
      armed_q  <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= under && mode_q;
      if (wr_en) armed_q <= (addr == A_K1) && (wr_data == KEY1);
      if (wr_ctl) begin
        sel_q  <= wr_data[7:5];
        run_q  <= wr_data[2];
        tof_q  <= wr_data[1];
        mode_q <= wr_data[0];
      end
      if (under) tof_q <= 1'b1;
      if (wr_en && addr == A_RLD) reload_q <= wr_data;

      if (feed) begin
        div_q <= '0;
        pre_q <= '0;
        cnt_q <= reload_q;
      end else if (run_q) begin
        div_q <= div_tc ? '0 : div_q + DIV_W'(1);
        if (under) begin
          pre_q <= '0;
          cnt_q <= reload_q;
        end else begin
          if (div_tc) pre_q <= pre_q + PRE_W'(1);
          if (tick)   cnt_q <= cnt_q - 8'd1;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rd_data = {sel_q, 2'b00, run_q, tof_q, mode_q};
      A_RLD:   rd_data = reload_q;
      A_K1:    rd_data = cnt_q;
      default: rd_data = 8'h00;
    endcase
  end

  assign wd_reset = pulse_q;
  assign tof_flag = tof_q;
  assign irq      = tof_q && !mode_q;
  assign running  = run_q;
endmodule

// File: rtl/wdt_tapped_chk.sv
module wdt_tapped_chk #(
  parameter int PRE_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wd_reset,
  input logic             tof_flag,
  input logic             irq,
  input logic             run_q,
  input logic [7:0]       cnt_q,
  input logic [PRE_W-1:0] pre_q
);
  a_r7_pulse_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset);

  a_r7_reset_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> tof_flag);

  a_r7_no_irq_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> !irq);

  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tof_flag) && !$past(wr_en)) |-> tof_flag);

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !$past(run_q) && !$past(wr_en)) |-> ($stable(cnt_q) && $stable(pre_q)));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $past(cnt_q) != 8'd0) |->
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 8'd1));
endmodule

bind wdt_tapped wdt_tapped_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wd_reset(wd_reset),
  .tof_flag(tof_flag), .irq(irq), .run_q(run_q), .cnt_q(cnt_q), .pre_q(pre_q)
);

// File: tb/tb_wdt_tapped.sv
module tb_wdt_tapped;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wd_reset, tof_flag, irq, running;

  wdt_tapped dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .wd_reset(wd_reset), .tof_flag(tof_flag), .irq(irq),
    .running(running)
  );

  always #5 clk = ~clk;

  typedef struct { int unsigned cyc; bit is_rst; string req; } exp_t;
  exp_t q[$];

  int unsigned cyc = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  bit prev_tof = 0, prev_rst = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic do_feed(output int unsigned f);
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
    f = cyc;
  endtask

  task automatic expect_ev(input int unsigned c, input bit r, input string req);
    exp_t e;
    e.cyc = c; e.is_rst = r; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_q;
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor: pops expected events as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rst && wd_reset) chk(0, "R7 reset pulse wider than one clock", 1, 0);
      if (wd_reset || (tof_flag && !prev_tof)) begin
        if (q.size() == 0) begin
          chk(0, "R6/R4 unexpected expiry", int'(cyc), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, {e.req, " expiry cycle"}, int'(cyc), int'(e.cyc));
          chk(wd_reset == e.is_rst, {e.req, " R7/R8 reset pulse"}, wd_reset, e.is_rst);
          chk(irq == !e.is_rst, {e.req, " R7/R8 irq"}, irq, !e.is_rst);
        end
      end
      prev_tof = tof_flag;
      prev_rst = wd_reset;
    end
  end

  initial begin
    int unsigned limit = 190000;
    while (!done && cyc < limit) @(negedge clk);
    if (!done) begin
      chk(0, "watchdog timeout", int'(cyc), int'(limit));
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    int unsigned f, s, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk(d == 8'h00, "R1 control reset", d, 8'h00);
    rd(2'd1, d); chk(d == 8'hFF, "R1 reload reset", d, 8'hFF);
    chk(!wd_reset, "R1 wd_reset low", wd_reset, 0);
    chk(!irq, "R1 irq low", irq, 0);
    chk(!running, "R1 running low", running, 0);

    // R2 R3 R8 R11: timer mode, select 0, reload 1
    wr(2'd1, 8'h01);
    rd(2'd1, d); chk(d == 8'h01, "R2 reload readback", d, 8'h01);
    wr(2'd0, 8'h04);
    chk(running, "R11 running follows run bit", running, 1);
    rd(2'd0, d); chk(d == 8'h04, "R2 control readback", d, 8'h04);
    do_feed(f);
    expect_ev(f + 768 * 2, 0, "R3 R8 sel0 W1");
    wait_q;
    repeat (10) @(negedge clk);
    rd(2'd0, d); chk(d[1], "R9 flag still set", d[1], 1);
    chk(irq, "R8 irq held with flag", irq, 1);
    wr(2'd0, 8'h00);
    chk(!irq, "R9 flag cleared by write of 0", irq, 0);
    chk(!running, "R11 running low after stop", running, 0);

    // R4 R7: watchdog mode, select 1, reload 0
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h25);
    do_feed(f);
    expect_ev(f + 1536, 1, "R4 R7 sel1 W0");
    wait_q;
    rd(2'd0, d); chk(d[1], "R7 flag set in watchdog mode", d[1], 1);
    wr(2'd0, 8'h00);

    // R3 select 2
    wr(2'd0, 8'h44);
    do_feed(f);
    expect_ev(f + 3072, 0, "R3 sel2 W0");
    wait_q;
    wr(2'd0, 8'h00);

    // R6: broken feed sequences must not reload
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h04);
    do_feed(f);
    expect_ev(f + 768 * 4, 0, "R6 bad feeds ignored");
    wr(2'd2, 8'hA5); wr(2'd3, 8'h00); wr(2'd3, 8'h5A);
    wr(2'd2, 8'hA5); wr(2'd0, 8'h04); wr(2'd3, 8'h5A);
    wr(2'd3, 8'h5A); wr(2'd2, 8'hA5);
    wr(2'd2, 8'hA4); wr(2'd3, 8'h5A);
    wait_q;
    wr(2'd0, 8'h00);

    // R5: a valid feed postpones expiry
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h04);
    do_feed(f);
    repeat (1000) @(negedge clk);
    rd(2'd2, d); chk(d == 8'h00, "R3 counter stepped once", d, 8'h00);
    do_feed(f);
    rd(2'd2, d); chk(d == 8'h01, "R5 feed reloads counter", d, 8'h01);
    expect_ev(f + 1536, 0, "R5 feed restarts period");
    wait_q;
    wr(2'd0, 8'h00);

    // R10: stop mid-tick, resume
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h04);
    do_feed(f);
    repeat (399) @(negedge clk);
    wr(2'd0, 8'h00);
    s = cyc;
    rd(2'd2, d);
    repeat (3000) @(negedge clk);
    rd(2'd2, d2);
    chk(d == d2, "R10 counter frozen", d2, d);
    wr(2'd0, 8'h04);
    r = cyc;
    expect_ev(r + 768 - (s - f), 0, "R10 resume keeps prescaler");
    wait_q;
    wr(2'd0, 8'h00);

    // R3 slowest tap
    wr(2'd0, 8'hE4);
    do_feed(f);
    expect_ev(f + 98304, 0, "R3 sel7 W0");
    wait_q;
    wr(2'd0, 8'h00);
    repeat (5) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule